// File: doc/BRIEF.md
# Masked Control Register Bank

This block holds the internal 64-bit control registers of a processor core behind a single index. Each index carries its own rule. It can keep only certain bits on a write, clear itself whenever written, or refuse reads or writes. A few indices raise a one-cycle side-effect pulse for a translation buffer that sits outside this block. One index merges a live cycle count into its read data.

A caller presents an index together with a read strobe, a write strobe, or both. The read data and the access-fault flag come back on the next cycle. The side-effect pulse also appears on the next cycle, carrying the index that caused it. While the speculative flag is high, a write leaves no trace: nothing is stored, no fault is raised and no pulse is emitted.

Top module: `ctl_reg_bank`

## Requirements
- R1: After reset every register reads zero except index 32 (miscellaneous control), which reads 0x6. `rd_data`, `acc_fault`, `evt_pulse` and `evt_idx` are zero.
- R2: A write stores `wr_data` AND a per-index mask. The masks are:
  - 0xf for indices 10 and 11.
  - 0x1f for index 12.
  - 0x18 for indices 13, 14 and 15.
  - 0x7fff0 for index 16.
  - 0xffffff0300 for index 17.
  - 0xffffffffc0000000 for indices 18 and 19.
  - 0x3f for indices 20 and 21.
  - 0x7f0 for index 22.
  - 0xfe00000000000000 for index 23.
  - All ones for indices 0-8, 31, 32, 33-36 and 41-44.
- R3: A write to index 9 (exception return address) stores the data with bit 1 forced to zero.
- R4: Any write to index 24 or 25 (exception summary and exception mask) leaves the register at zero.
- R5: A non-speculative write to indices 26-30 raises `acc_fault` and leaves the stored value unchanged.
- R6: A read of index 15 or of indices 33-44 raises `acc_fault` and returns zero on `rd_data`.
- R7: Indices 45-63 do not exist. Reading one, or writing one non-speculatively, raises `acc_fault`.
- R8: Reading index 31 returns the stored bits 63:32 above `cyc_cnt` in bits 31:0, with `cyc_cnt` sampled in the cycle of the read strobe.
- R9: While `spec` is high, a write changes no register, raises no fault and emits no pulse.
- R10: A committed write to indices 37-44 sets `evt_pulse` for exactly one cycle, one cycle later, with `evt_idx` equal to the index. The write-enable indices 37-40 store zero. Otherwise `evt_idx` is zero.
- R11: `rd_data` and `acc_fault` are registered and appear one cycle after the strobe. `rd_data` holds its value until the next read. A read and a write to the same index in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx | input | 6 | Register index |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| spec | input | 1 | Speculative flag; suppresses writes |
| cyc_cnt | input | 32 | Low half of the free-running cycle counter |
| rd_data | output | 64 | Registered read data |
| acc_fault | output | 1 | Access fault for the previous cycle's access |
| evt_pulse | output | 1 | One-cycle side-effect pulse |
| evt_idx | output | 6 | Index that produced the pulse |

## Verification
The bench writes all ones to every masked index and reads each value back. A wrong mask shows up as a stray bit, and a missing bit-1 clear at index 9 shows up as bit 1 set. It also hits the forbidden directions: writes to the read-only indices, reads of the write-only indices, and indices past the implemented range. A decoder that let one of these through would either miss the fault or leak stored data.

Speculative writes are aimed at plain registers and at pulse-raising indices. A design that ignored `spec` would change stored data or emit a pulse. Reads of index 31 use a fresh cycle value each time, so a stale or unmerged low half is caught. A read and a write in the same cycle to the same index catch a design that forwards the new data into the read.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;
  localparam int DW       = 64;
  localparam int HALF     = DW / 2;
  localparam int IDX_W    = 6;
  localparam int NUM_IMPL = 45;

  localparam int IX_TRAP_BASE = 8;
  localparam int IX_EXC_RET   = 9;
  localparam int IX_AST_REQ   = 10;
  localparam int IX_AST_EN    = 11;
  localparam int IX_LEVEL     = 12;
  localparam int IX_CUR_MODE  = 13;
  localparam int IX_DMODE     = 14;
  localparam int IX_ALT_MODE  = 15;
  localparam int IX_SW_INT    = 16;
  localparam int IX_CTLSTAT   = 17;
  localparam int IX_IPT_BASE  = 18;
  localparam int IX_MPT_BASE  = 19;
  localparam int IX_DC_MODE   = 20;
  localparam int IX_MISS_MODE = 21;
  localparam int IX_I_ASN     = 22;
  localparam int IX_D_ASN     = 23;
  localparam int IX_EXC_SUM   = 24;
  localparam int IX_EXC_MSK   = 25;
  localparam int IX_RO_FIRST  = 26;
  localparam int IX_RO_LAST   = 30;
  localparam int IX_CYCLE     = 31;
  localparam int IX_MISC      = 32;
  localparam int IX_WO_FIRST  = 33;
  localparam int IX_EVT_FIRST = 37;
  localparam int IX_INV_LAST  = 40;
  localparam int IX_EVT_LAST  = 44;

  localparam logic [DW-1:0] MISC_RESET = 64'h6;

  typedef struct packed {
    logic rd_ok;
    logic wr_ok;
    logic evt;
  } attr_t;

  function automatic attr_t reg_attr(input int i);
    attr_t a;
    logic known;
    known   = (i >= 0) && (i < NUM_IMPL);
    a.rd_ok = known && !(i == IX_ALT_MODE || (i >= IX_WO_FIRST && i <= IX_EVT_LAST));
    a.wr_ok = known && !(i >= IX_RO_FIRST && i <= IX_RO_LAST);
    a.evt   = (i >= IX_EVT_FIRST) && (i <= IX_EVT_LAST);
    return a;
  endfunction

  function automatic logic [DW-1:0] wr_mask(input int i);
    logic [DW-1:0] m;
    m = '1;
    case (i)
      IX_EXC_RET:                 m = ~64'h2;
      IX_AST_REQ, IX_AST_EN:      m = 64'hf;
      IX_LEVEL:                   m = 64'h1f;
      IX_CUR_MODE, IX_DMODE,
      IX_ALT_MODE:                m = 64'h18;
      IX_SW_INT:                  m = 64'h7fff0;
      IX_CTLSTAT:                 m = 64'hff_ffff_0300;
      IX_IPT_BASE, IX_MPT_BASE:   m = 64'hffff_ffff_c000_0000;
      IX_DC_MODE, IX_MISS_MODE:   m = 64'h3f;
      IX_I_ASN:                   m = 64'h7f0;
      IX_D_ASN:                   m = 64'hfe00_0000_0000_0000;
      IX_EXC_SUM, IX_EXC_MSK:     m = '0;
      default: begin
        if (i >= IX_RO_FIRST && i <= IX_RO_LAST) m = '0;
        if (i >= IX_EVT_FIRST && i <= IX_INV_LAST) m = '0;
      end
    endcase
    return m;
  endfunction

  function automatic logic [DW-1:0] rst_val(input int i);
    return (i == IX_MISC) ? MISC_RESET : '0;
  endfunction

  function automatic logic [DW-1:0] merge_cycle(input logic [DW-1:0] stored,
                                                input logic [HALF-1:0] live);
    return {stored[DW-1:HALF], live};
  endfunction
endpackage

// File: rtl/ctl_reg_decode.sv
module ctl_reg_decode
  import ctl_reg_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic             spec,
  output logic             wr_commit,
  output logic             wr_fault,
  output logic             rd_fault,
  output logic             rd_ok,
  output logic             evt_fire
);
  attr_t a;
  logic  wr_live;

  always_comb a = reg_attr(int'(idx));

  assign wr_live   = wr_en & ~spec;
  assign wr_commit = wr_live & a.wr_ok;
  assign wr_fault  = wr_live & ~a.wr_ok;
  assign rd_fault  = rd_en & ~a.rd_ok;
  assign rd_ok     = a.rd_ok;
  assign evt_fire  = wr_commit & a.evt;
endmodule

// File: rtl/ctl_reg_store.sv
module ctl_reg_store
  import ctl_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_commit,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    bank_q [NUM_IMPL]
);
  for (genvar g = 0; g < NUM_IMPL; g++) begin : g_ent
    localparam logic [DW-1:0] MASK = wr_mask(g);
    localparam logic [DW-1:0] RST  = rst_val(g);
    logic hit;
    assign hit = wr_commit && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bank_q[g] <= RST;
      else if (hit) bank_q[g] <= wr_data & MASK;
    end
  end
endmodule

// File: rtl/ctl_reg_rdport.sv
module ctl_reg_rdport
  import ctl_reg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic            rd_ok,
  input  logic            is_cycle,
  input  logic [DW-1:0]   sel_word,
  input  logic [HALF-1:0] cyc_lo,
  input  logic            fault_now,
  output logic [DW-1:0]   rd_data,
  output logic            acc_fault
);
  logic [DW-1:0] rd_next;

  always_comb begin
    if (!rd_ok)        rd_next = '0;
    else if (is_cycle) rd_next = merge_cycle(sel_word, cyc_lo);
    else               rd_next = sel_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      acc_fault <= 1'b0;
    end else begin
      acc_fault <= fault_now;
      if (rd_en) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/ctl_reg_event.sv
module ctl_reg_event
  import ctl_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_fire,
  input  logic [IDX_W-1:0] idx,
  output logic             evt_pulse,
  output logic [IDX_W-1:0] evt_idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_pulse <= 1'b0;
      evt_idx   <= '0;
    end else begin
      evt_pulse <= evt_fire;
      evt_idx   <= evt_fire ? idx : '0;
    end
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic             spec,
  input  logic [HALF-1:0]  cyc_cnt,
  output logic [DW-1:0]    rd_data,
  output logic             acc_fault,
  output logic             evt_pulse,
  output logic [IDX_W-1:0] evt_idx
);
  logic          wr_commit, wr_fault, rd_fault, rd_ok, evt_fire;
  logic          is_cycle;
  logic [DW-1:0] sel_word;
  logic [DW-1:0] bank_q [NUM_IMPL];

  ctl_reg_decode u_dec (
    .idx       (idx),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .spec      (spec),
    .wr_commit (wr_commit),
    .wr_fault  (wr_fault),
    .rd_fault  (rd_fault),
    .rd_ok     (rd_ok),
    .evt_fire  (evt_fire)
  );

  ctl_reg_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_commit (wr_commit),
    .wr_idx    (idx),
    .wr_data   (wr_data),
    .bank_q    (bank_q)
  );

  always_comb begin
    sel_word = '0;
    for (int k = 0; k < NUM_IMPL; k++)
      if (idx == IDX_W'(k)) sel_word = bank_q[k];
  end

  assign is_cycle = (idx == IDX_W'(IX_CYCLE));

  ctl_reg_rdport u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_ok     (rd_ok),
    .is_cycle  (is_cycle),
    .sel_word  (sel_word),
    .cyc_lo    (cyc_cnt),
    .fault_now (rd_fault | wr_fault),
    .rd_data   (rd_data),
    .acc_fault (acc_fault)
  );

  ctl_reg_event u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_fire  (evt_fire),
    .idx       (idx),
    .evt_pulse (evt_pulse),
    .evt_idx   (evt_idx)
  );
endmodule

// File: rtl/ctl_reg_bank_chk.sv
module ctl_reg_bank_chk
  import ctl_reg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] idx,
  input logic [DW-1:0]    wr_data,
  input logic             rd_en,
  input logic             wr_en,
  input logic             spec,
  input logic [HALF-1:0]  cyc_cnt,
  input logic [DW-1:0]    rd_data,
  input logic             acc_fault,
  input logic             evt_pulse,
  input logic [IDX_W-1:0] evt_idx
);
  assert_cycle_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && idx == IDX_W'(IX_CYCLE) |=> rd_data[HALF-1:0] == $past(cyc_cnt));

  assert_exc_bit1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && idx == IDX_W'(IX_EXC_RET) |=> !rd_data[1]);

  assert_clear_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (idx == IDX_W'(IX_EXC_SUM) || idx == IDX_W'(IX_EXC_MSK)) |=> rd_data == '0);

  assert_level_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && idx == IDX_W'(IX_LEVEL) |=> rd_data[DW-1:5] == '0);

  assert_scratch_roundtrip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !spec && !rd_en && idx == '0 ##1 rd_en && !wr_en && idx == '0
      |=> rd_data == $past(wr_data, 2));

  assert_wo_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && idx == IDX_W'(IX_ALT_MODE) |=> acc_fault && rd_data == '0);

  assert_unknown_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || (wr_en && !spec)) && idx >= IDX_W'(NUM_IMPL) |=> acc_fault);

  assert_spec_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && spec && !rd_en |=> !acc_fault && !evt_pulse);

  assert_evt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> evt_idx >= IDX_W'(IX_EVT_FIRST) && evt_idx <= IDX_W'(IX_EVT_LAST));

  assert_evt_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_pulse |-> evt_idx == '0);
endmodule

bind ctl_reg_bank ctl_reg_bank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .idx       (idx),
  .wr_data   (wr_data),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .spec      (spec),
  .cyc_cnt   (cyc_cnt),
  .rd_data   (rd_data),
  .acc_fault (acc_fault),
  .evt_pulse (evt_pulse),
  .evt_idx   (evt_idx)
);

// File: tb/ctl_reg_bank_test.sv
`timescale 1ns/1ps
module ctl_reg_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  idx = '0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0, spec = 1'b0;
  logic [31:0] cyc_cnt = '0;
  logic [63:0] rd_data;
  logic        acc_fault, evt_pulse;
  logic [5:0]  evt_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [63:0] model [64];
  logic [63:0] exp_rd = '0;

  always #2.5 clk = ~clk;

  ctl_reg_bank uut (
    .clk(clk), .rst_n(rst_n), .idx(idx), .wr_data(wr_data), .rd_en(rd_en),
    .wr_en(wr_en), .spec(spec), .cyc_cnt(cyc_cnt), .rd_data(rd_data),
    .acc_fault(acc_fault), .evt_pulse(evt_pulse), .evt_idx(evt_idx)
  );

  function automatic bit b_exists(int i); return i < 45; endfunction
  function automatic bit b_can_rd(int i);
    return b_exists(i) && i != 15 && (i < 33 || i > 44);
  endfunction
  function automatic bit b_can_wr(int i);
    return b_exists(i) && (i < 26 || i > 30);
  endfunction
  function automatic bit b_pulses(int i); return i >= 37 && i <= 44; endfunction
  function automatic logic [63:0] b_mask(int i);
    if (i == 9) return 64'hffff_ffff_ffff_fffd;
    if (i == 10 || i == 11) return 64'hf;
    if (i == 12) return 64'h1f;
    if (i >= 13 && i <= 15) return 64'h18;
    if (i == 16) return 64'h7fff0;
    if (i == 17) return 64'hff_ffff_0300;
    if (i == 18 || i == 19) return 64'hffff_ffff_c000_0000;
    if (i == 20 || i == 21) return 64'h3f;
    if (i == 22) return 64'h7f0;
    if (i == 23) return 64'hfe00_0000_0000_0000;
    if (i == 24 || i == 25) return 64'h0;
    if (i >= 37 && i <= 40) return 64'h0;
    return 64'hffff_ffff_ffff_ffff;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(int i, logic [63:0] d, bit r, bit w, bit s, string tag);
    logic [31:0] cyc;
    bit exp_f, exp_e;
    cyc = $urandom;
    idx = 6'(i); wr_data = d; rd_en = r; wr_en = w; spec = s; cyc_cnt = cyc;
    exp_f = (r && !b_can_rd(i)) || (w && !s && !b_can_wr(i));
    exp_e = w && !s && b_pulses(i);
    if (r) begin
      if (!b_can_rd(i))  exp_rd = '0;
      else if (i == 31)  exp_rd = {model[31][63:32], cyc};
      else               exp_rd = model[i];
    end
    if (w && !s && b_can_wr(i)) model[i] = d & b_mask(i);
    @(negedge clk);
    check(tag, "rd_data", rd_data, exp_rd);
    check(tag, "acc_fault", 64'(acc_fault), 64'(exp_f));
    check(tag, "evt_pulse", 64'(evt_pulse), 64'(exp_e));
    check(tag, "evt_idx", 64'(evt_idx), exp_e ? 64'(i) : 64'd0);
  endtask

  function automatic string tag_of(int i, bit r, bit w, bit s);
    if (w && s) return "R9";
    if (!b_exists(i)) return "R7";
    if (w && b_pulses(i)) return "R10";
    if (r && !b_can_rd(i)) return "R6";
    if (w && !b_can_wr(i)) return "R5";
    if (i == 31) return "R8";
    if (i == 9) return "R3";
    if (i == 24 || i == 25) return "R4";
    if (r && w) return "R11";
    return "R2";
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    for (int k = 0; k < 64; k++) model[k] = (k == 32) ? 64'h6 : 64'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs idle after reset
    check("R1", "rd_data", rd_data, 64'h0);
    check("R1", "acc_fault", 64'(acc_fault), 64'h0);
    check("R1", "evt_pulse", 64'(evt_pulse), 64'h0);
    for (int k = 0; k < 45; k++)
      if (b_can_rd(k)) apply(k, 64'h0, 1, 0, 0, "R1");
    // R2: all-ones into masked indices
    for (int k = 10; k <= 23; k++) begin
      apply(k, '1, 0, 1, 0, "R2");
      apply(k, '0, 1, 0, 0, "R2");
    end
    apply(0, 64'h0123_4567_89ab_cdef, 0, 1, 0, "R2");
    apply(0, '0, 1, 0, 0, "R2");
    apply(9, '1, 0, 1, 0, "R3");
    apply(9, '0, 1, 0, 0, "R3");
    apply(24, '1, 0, 1, 0, "R4");
    apply(24, '0, 1, 0, 0, "R4");
    apply(25, 64'h55, 1, 1, 0, "R4");
    apply(26, '1, 0, 1, 0, "R5");
    apply(26, '0, 1, 0, 0, "R5");
    apply(15, '0, 1, 0, 0, "R6");
    apply(33, '0, 1, 0, 0, "R6");
    apply(50, '0, 1, 0, 0, "R7");
    apply(63, '1, 0, 1, 0, "R7");
    apply(31, 64'hdead_beef_0000_1111, 0, 1, 0, "R8");
    apply(31, '0, 1, 0, 0, "R8");
    apply(31, '0, 1, 0, 0, "R8");
    apply(1, 64'hffff, 0, 1, 1, "R9");
    apply(1, '0, 1, 0, 0, "R9");
    apply(26, '1, 0, 1, 1, "R9");
    apply(38, '1, 0, 1, 1, "R9");
    apply(37, '1, 0, 1, 0, "R10");
    apply(41, 64'h77, 0, 1, 0, "R10");
    apply(0, '0, 0, 0, 0, "R10");
    apply(2, 64'haaaa, 0, 1, 0, "R11");
    apply(2, 64'h5555, 1, 1, 0, "R11");
    apply(2, '0, 0, 0, 0, "R11");
    apply(2, '0, 1, 0, 0, "R11");
    for (int n = 0; n < 4000; n++) begin
      int i;
      bit r, w, s;
      i = ($urandom % 10 < 8) ? int'($urandom % 45) : int'($urandom % 64);
      r = 1'($urandom); w = 1'($urandom); s = ($urandom % 5) == 0;
      apply(i, {$urandom, $urandom}, r, w, s, tag_of(i, r, w, s));
    end
    rd_en = 0; wr_en = 0; spec = 0;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule